// File: doc/BRIEF.md
# I2C Slave Receiver with Two-Pass 10-Bit Addressing

This block is the receive side of an I2C slave that runs on a fast system clock. It samples the bus clock and data lines through a synchronizer and finds their edges. It recognises START, repeated START and STOP. It shifts each incoming byte into a shift register. It can work in 7-bit or 10-bit addressing mode, matching against an address register that software programs.

When a byte is accepted, the block acknowledges it by pulling SDA low. It copies the byte into a holding buffer and raises an interrupt flag. Acceptance is gated by two sticky status flags, buffer-full and overflow. If either one is set, the byte is refused: the buffer keeps its old contents, no ACK is given, and the interrupt is still raised.

In 10-bit mode the address is checked in two passes through the one address register. After each address byte, the block raises an update request and holds SCL low. The hold lasts until software writes the other half of the address. After a repeated START that follows a complete 10-bit match, only the header byte is checked and no update is requested.

The bus outputs are active-high pull-low enables, meant for open-drain pads. A small strobe-driven CPU port gives access to the buffer read, the address write, the overflow clear and the interrupt clear.

Top module: `i2c_slave_rx`

## Requirements
- R1: After reset, both pull-low enables are low and buffer-full, overflow, interrupt and update-request are all 0.
- R2: START is SDA falling while SCL is high, and STOP is SDA rising while SCL is high. In 7-bit mode, an address byte is matched when its bits 7..1 equal bits 7..1 of the address register; bit 0 (R/W) is not compared. A matched byte is acknowledged. A mismatched byte gets no ACK and raises no interrupt, and the rest of the transfer up to the next START is ignored.
- R3: If a matched address byte or a data byte completes while buffer-full is set, the byte is not acknowledged, the buffer keeps its old value, and overflow is set.
- R4: While overflow is set, every matched or data byte is refused, even when buffer-full is clear. Reading the buffer and clearing the interrupt leave overflow set. Only the overflow-clear strobe clears it.
- R5: An accepted byte is copied to the buffer and sets buffer-full. A buffer read strobe clears buffer-full.
- R6: The interrupt flag is set at the falling edge of the 9th SCL pulse of every accepted or refused byte. It stays set until the interrupt-clear strobe.
- R7: In 10-bit mode, the first address byte is matched when it reads 11110 A9 A8 0 (R/W = 0) and its bits 7..1 equal the address register. When accepted, it is acknowledged and update-request is set. SCL is then held low until software writes the address register, which clears update-request and releases SCL.
- R8: In 10-bit mode, the second address byte is compared with all 8 bits of the address register. A match is acknowledged and sets update-request and the SCL hold. A mismatch gets no ACK, no interrupt and no hold.
- R9: In 10-bit mode, a header byte with R/W = 1 that does not follow a completed 10-bit match is not acknowledged.
- R10: After a repeated START that follows a completed 10-bit match, a header byte that matches (with R/W either 0 or 1) is acknowledged without setting update-request. STOP cancels the completed match.
- R11: SDA is pulled low only for the acknowledge clock of an accepted byte. SCL is pulled low only while update-request is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, well above the SCL rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| ten_bit_i | input | 1 | 1 selects 10-bit addressing, 0 selects 7-bit |
| scl_i | input | 1 | SCL level seen on the bus |
| sda_i | input | 1 | SDA level seen on the bus |
| scl_pull_o | output | 1 | 1 pulls SCL low (clock hold) |
| sda_pull_o | output | 1 | 1 pulls SDA low (acknowledge) |
| cpu_rd_i | input | 1 | Buffer read strobe, clears buffer-full |
| cpu_buf_o | output | 8 | Holding buffer contents |
| cpu_addr_we_i | input | 1 | Address register write strobe |
| cpu_addr_i | input | 8 | Address register write data |
| cpu_ovf_clr_i | input | 1 | Overflow clear strobe |
| cpu_irq_clr_i | input | 1 | Interrupt clear strobe |
| buf_full_o | output | 1 | Buffer-full flag |
| ovf_o | output | 1 | Overflow flag |
| irq_o | output | 1 | Interrupt flag |
| addr_upd_o | output | 1 | Update-request flag (10-bit mode) |

## Verification
The 7-bit address match is exercised with a table of address bytes. Some differ only in the R/W bit, which must still match. Others differ in the lowest or highest compared bit, which must be refused. Each matched entry is followed by a data byte, which separates an address-phase acceptance from a data-phase one. Directed sequences then hold the buffer unread and leave overflow set, so that gating by buffer-full can be told apart from gating by overflow. The 10-bit sequence covers a full two-pass match, a second address byte that does not match, a header with R/W set and no prior match, and a repeated START after a completed match. These four cases separate the stretching paths from the header-only path.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;

  localparam int BYTE_W = 8;
  localparam logic [4:0] TEN_PREFIX = 5'b11110;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_LO,
    ST_DATA,
    ST_SKIP
  } slv_state_e;

  // Seven-bit compare: R/W bit excluded
  function automatic logic addr7_hit(input logic [BYTE_W-1:0] sr,
                                     input logic [BYTE_W-1:0] ar);
    return sr[BYTE_W-1:1] == ar[BYTE_W-1:1];
  endfunction

  // Ten-bit header: fixed prefix plus compare of bits 7..1
  function automatic logic ten_hdr_hit(input logic [BYTE_W-1:0] sr,
                                       input logic [BYTE_W-1:0] ar);
    return (sr[BYTE_W-1:BYTE_W-5] == TEN_PREFIX) && addr7_hit(sr, ar);
  endfunction

endpackage

// File: rtl/i2cs_sync_edge.sv
module i2cs_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic sda_s_o,
  output logic start_o,
  output logic stop_o
);

  logic [STAGES-1:0] scl_pipe;
  logic [STAGES-1:0] sda_pipe;
  logic              scl_prev;
  logic              sda_prev;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) begin
            scl_pipe[g] <= 1'b1;
            sda_pipe[g] <= 1'b1;
          end else begin
            scl_pipe[g] <= scl_i;
            sda_pipe[g] <= sda_i;
          end
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) begin
            scl_pipe[g] <= 1'b1;
            sda_pipe[g] <= 1'b1;
          end else begin
            scl_pipe[g] <= scl_pipe[g-1];
            sda_pipe[g] <= sda_pipe[g-1];
          end
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_prev <= 1'b1;
      sda_prev <= 1'b1;
    end else begin
      scl_prev <= scl_pipe[STAGES-1];
      sda_prev <= sda_pipe[STAGES-1];
    end
  end

  logic scl_s;
  assign scl_s      = scl_pipe[STAGES-1];
  assign sda_s_o    = sda_pipe[STAGES-1];
  assign scl_rise_o = scl_s & ~scl_prev;
  assign scl_fall_o = ~scl_s & scl_prev;
  assign start_o    = scl_s & scl_prev & sda_prev & ~sda_s_o;
  assign stop_o     = scl_s & scl_prev & ~sda_prev & sda_s_o;

endmodule

// File: rtl/i2cs_shifter.sv
module i2cs_shifter
  import i2cs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              sda_s_i,
  output logic [BYTE_W-1:0] shreg_o,
  output logic              byte_end_o,
  output logic              ack_end_o
);

  localparam int CNT_W = $clog2(BYTE_W + 2);
  localparam logic [CNT_W-1:0] LAST_DATA = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] ACK_SLOT  = CNT_W'(BYTE_W + 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      shreg_o <= '0;
    end else if (clr_i) begin
      cnt_q <= '0;
    end else if (scl_rise_i) begin
      if (cnt_q < LAST_DATA) shreg_o <= {shreg_o[BYTE_W-2:0], sda_s_i};
      if (cnt_q < ACK_SLOT)  cnt_q   <= cnt_q + 1'b1;
    end else if (scl_fall_i && cnt_q == ACK_SLOT) begin
      cnt_q <= '0;
    end
  end

  assign byte_end_o = scl_fall_i & (cnt_q == LAST_DATA) & ~clr_i;
  assign ack_end_o  = scl_fall_i & (cnt_q == ACK_SLOT) & ~clr_i;

endmodule

// File: rtl/i2cs_ctrl.sv
module i2cs_ctrl
  import i2cs_pkg::*;
#(
  parameter logic [BYTE_W-1:0] RESET_ADDR = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ten_bit_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              byte_end_i,
  input  logic              ack_end_i,
  input  logic [BYTE_W-1:0] shreg_i,
  input  logic              cpu_rd_i,
  input  logic              cpu_addr_we_i,
  input  logic [BYTE_W-1:0] cpu_addr_i,
  input  logic              cpu_ovf_clr_i,
  input  logic              cpu_irq_clr_i,
  output logic [BYTE_W-1:0] buf_o,
  output logic              bf_o,
  output logic              ovf_o,
  output logic              irq_o,
  output logic              upd_o,
  output logic              sda_pull_o,
  output logic              scl_pull_o,
  output logic              byte_hit_o
);

  slv_state_e        state_q;
  slv_state_e        nxt_state;
  logic [BYTE_W-1:0] addr_q;
  logic              ten_done_q;
  logic              ack_q;
  logic              irq_pend_q;
  logic              upd_pend_q;
  logic              hit;
  logic              upd_want;
  logic              lo_pass;
  logic              accept;
  logic              bus_evt;

  always_comb begin
    hit       = 1'b0;
    upd_want  = 1'b0;
    lo_pass   = 1'b0;
    nxt_state = ST_SKIP;
    unique case (state_q)
      ST_ADDR: begin
        nxt_state = ST_DATA;
        if (!ten_bit_i) begin
          hit = addr7_hit(shreg_i, addr_q);
        end else if (ten_done_q) begin
          hit = ten_hdr_hit(shreg_i, addr_q);
        end else begin
          hit       = ten_hdr_hit(shreg_i, addr_q) & ~shreg_i[0];
          upd_want  = 1'b1;
          nxt_state = ST_ADDR_LO;
        end
      end
      ST_ADDR_LO: begin
        hit       = (shreg_i == addr_q);
        upd_want  = 1'b1;
        lo_pass   = 1'b1;
        nxt_state = ST_DATA;
      end
      ST_DATA: begin
        hit       = 1'b1;
        nxt_state = ST_DATA;
      end
      default: begin
        hit = 1'b0;
      end
    endcase
  end

  assign byte_hit_o = byte_end_i & hit;
  assign accept     = byte_hit_o & ~bf_o & ~ovf_o;
  assign bus_evt    = start_i | stop_i;

  // Transfer state and ten-bit completion
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      ten_done_q <= 1'b0;
    end else if (stop_i) begin
      state_q    <= ST_IDLE;
      ten_done_q <= 1'b0;
    end else if (start_i) begin
      state_q <= ST_ADDR;
    end else if (byte_end_i) begin
      if (accept)                 state_q <= nxt_state;
      else if (state_q != ST_DATA) state_q <= ST_SKIP;
      if (accept && lo_pass)      ten_done_q <= 1'b1;
    end
  end

  // Acknowledge drive and per-byte pending events
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_q      <= 1'b0;
      irq_pend_q <= 1'b0;
      upd_pend_q <= 1'b0;
    end else if (bus_evt || ack_end_i) begin
      ack_q      <= 1'b0;
      irq_pend_q <= 1'b0;
      upd_pend_q <= 1'b0;
    end else if (byte_end_i) begin
      ack_q      <= accept;
      irq_pend_q <= byte_hit_o;
      upd_pend_q <= accept & upd_want;
    end
  end

  // Status flags; a set in the same cycle wins over a clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_o <= 1'b0;
      upd_o <= 1'b0;
      ovf_o <= 1'b0;
      bf_o  <= 1'b0;
      buf_o <= '0;
    end else begin
      if (ack_end_i && irq_pend_q) irq_o <= 1'b1;
      else if (cpu_irq_clr_i)      irq_o <= 1'b0;

      if (ack_end_i && upd_pend_q) upd_o <= 1'b1;
      else if (cpu_addr_we_i)      upd_o <= 1'b0;

      if (byte_hit_o && bf_o)      ovf_o <= 1'b1;
      else if (cpu_ovf_clr_i)      ovf_o <= 1'b0;

      if (accept) begin
        buf_o <= shreg_i;
        bf_o  <= 1'b1;
      end else if (cpu_rd_i) begin
        bf_o <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             addr_q <= RESET_ADDR;
    else if (cpu_addr_we_i) addr_q <= cpu_addr_i;
  end

  assign sda_pull_o = ack_q;
  assign scl_pull_o = upd_o;

endmodule

// File: rtl/i2c_slave_rx.sv
module i2c_slave_rx
  import i2cs_pkg::*;
#(
  parameter int                SYNC_STAGES = 2,
  parameter logic [BYTE_W-1:0] RESET_ADDR  = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ten_bit_i,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              scl_pull_o,
  output logic              sda_pull_o,
  input  logic              cpu_rd_i,
  output logic [BYTE_W-1:0] cpu_buf_o,
  input  logic              cpu_addr_we_i,
  input  logic [BYTE_W-1:0] cpu_addr_i,
  input  logic              cpu_ovf_clr_i,
  input  logic              cpu_irq_clr_i,
  output logic              buf_full_o,
  output logic              ovf_o,
  output logic              irq_o,
  output logic              addr_upd_o
);

  // Named internal events, also used by the bound checker
  logic              scl_rise_w;
  logic              scl_fall_w;
  logic              sda_s_w;
  logic              start_w;
  logic              stop_w;
  logic              byte_end_w;
  logic              ack_end_w;
  logic              byte_hit_w;
  logic [BYTE_W-1:0] shreg_w;

  i2cs_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .scl_rise_o (scl_rise_w),
    .scl_fall_o (scl_fall_w),
    .sda_s_o    (sda_s_w),
    .start_o    (start_w),
    .stop_o     (stop_w)
  );

  i2cs_shifter u_shift (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr_i      (start_w | stop_w),
    .scl_rise_i (scl_rise_w),
    .scl_fall_i (scl_fall_w),
    .sda_s_i    (sda_s_w),
    .shreg_o    (shreg_w),
    .byte_end_o (byte_end_w),
    .ack_end_o  (ack_end_w)
  );

  i2cs_ctrl #(.RESET_ADDR(RESET_ADDR)) u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .ten_bit_i     (ten_bit_i),
    .start_i       (start_w),
    .stop_i        (stop_w),
    .byte_end_i    (byte_end_w),
    .ack_end_i     (ack_end_w),
    .shreg_i       (shreg_w),
    .cpu_rd_i      (cpu_rd_i),
    .cpu_addr_we_i (cpu_addr_we_i),
    .cpu_addr_i    (cpu_addr_i),
    .cpu_ovf_clr_i (cpu_ovf_clr_i),
    .cpu_irq_clr_i (cpu_irq_clr_i),
    .buf_o         (cpu_buf_o),
    .bf_o          (buf_full_o),
    .ovf_o         (ovf_o),
    .irq_o         (irq_o),
    .upd_o         (addr_upd_o),
    .sda_pull_o    (sda_pull_o),
    .scl_pull_o    (scl_pull_o),
    .byte_hit_o    (byte_hit_w)
  );

endmodule

// File: rtl/i2cs_checker.sv
module i2cs_checker (
  input logic clk,
  input logic rst_n,
  input logic byte_hit,
  input logic ack_end,
  input logic bf,
  input logic ovf,
  input logic irq,
  input logic upd,
  input logic sda_pull,
  input logic scl_pull,
  input logic cpu_rd,
  input logic cpu_addr_we,
  input logic cpu_ovf_clr
);

  // R3: a matched byte arriving with the buffer full raises overflow
  a_r3_ovf_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    byte_hit && bf |=> ovf);

  // R3: a blocked byte is never acknowledged
  a_r3_nack_when_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    byte_hit && (bf || ovf) |=> !sda_pull);

  // R4: overflow survives everything except its clear strobe
  a_r4_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ovf && !cpu_ovf_clr |=> ovf);

  // R5: an unblocked byte sets buffer-full and acknowledges
  a_r5_accept_loads: assert property (@(posedge clk) disable iff (!rst_n)
    byte_hit && !bf && !ovf |=> bf && sda_pull);

  // R5: a buffer read clears buffer-full
  a_r5_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rd && bf |=> !bf);

  // R6: the end of an acknowledged clock raises the interrupt
  a_r6_irq_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
    ack_end && sda_pull |=> irq);

  // R7: the clock hold lasts until the address register is written
  a_r7_stretch_held: assert property (@(posedge clk) disable iff (!rst_n)
    upd && !cpu_addr_we |=> upd && scl_pull);

  // R7: an address write releases the clock
  a_r7_write_releases: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_addr_we && !ack_end |=> !scl_pull && !upd);

  // R11: SDA pull starts only right after a matched byte
  a_r11_ack_origin: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_pull) |-> $past(byte_hit));

endmodule

bind i2c_slave_rx i2cs_checker u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .byte_hit    (byte_hit_w),
  .ack_end     (ack_end_w),
  .bf          (buf_full_o),
  .ovf         (ovf_o),
  .irq         (irq_o),
  .upd         (addr_upd_o),
  .sda_pull    (sda_pull_o),
  .scl_pull    (scl_pull_o),
  .cpu_rd      (cpu_rd_i),
  .cpu_addr_we (cpu_addr_we_i),
  .cpu_ovf_clr (cpu_ovf_clr_i)
);

// File: tb/sim_i2c_slave_rx.sv
module sim_i2c_slave_rx;

  localparam int PH = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ten_bit = 1'b0;
  logic       scl_m = 1'b1;
  logic       sda_m = 1'b1;
  logic       cpu_rd = 1'b0;
  logic       cpu_addr_we = 1'b0;
  logic [7:0] cpu_addr = 8'h00;
  logic       cpu_ovf_clr = 1'b0;
  logic       cpu_irq_clr = 1'b0;
  logic       scl_pull, sda_pull, bf, ovf, irq, upd;
  logic [7:0] bufv;
  logic       scl_line, sda_line;
  int         n_chk = 0;
  int         n_fail = 0;
  bit         done = 1'b0;

  always #10 clk = ~clk;

  assign scl_line = scl_m & ~scl_pull;
  assign sda_line = sda_m & ~sda_pull;

  i2c_slave_rx u0 (
    .clk(clk), .rst_n(rst_n), .ten_bit_i(ten_bit),
    .scl_i(scl_line), .sda_i(sda_line),
    .scl_pull_o(scl_pull), .sda_pull_o(sda_pull),
    .cpu_rd_i(cpu_rd), .cpu_buf_o(bufv),
    .cpu_addr_we_i(cpu_addr_we), .cpu_addr_i(cpu_addr),
    .cpu_ovf_clr_i(cpu_ovf_clr), .cpu_irq_clr_i(cpu_irq_clr),
    .buf_full_o(bf), .ovf_o(ovf), .irq_o(irq), .addr_upd_o(upd)
  );

  // address byte, data byte, expected ACK (7-bit address 7'h42)
  localparam logic [16:0] VEC [0:5] = '{
    {8'h84, 8'h5A, 1'b1},
    {8'h85, 8'hC3, 1'b1},
    {8'h86, 8'h00, 1'b0},
    {8'h04, 8'h00, 1'b0},
    {8'h84, 8'hFF, 1'b1},
    {8'hA4, 8'h00, 1'b0}
  };

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wait_scl_high();
    while (!scl_line) tick(1);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; tick(PH);
    scl_m = 1'b1; wait_scl_high(); tick(PH);
    sda_m = 1'b0; tick(PH);
    scl_m = 1'b0; tick(PH);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(PH);
    scl_m = 1'b1; wait_scl_high(); tick(PH);
    sda_m = 1'b1; tick(PH);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; tick(PH);
      scl_m = 1'b1; wait_scl_high(); tick(PH);
      scl_m = 1'b0; tick(2);
    end
    sda_m = 1'b1; tick(PH);
    scl_m = 1'b1; wait_scl_high(); tick(PH / 2);
    ack = ~sda_line;
    tick(PH / 2);
    scl_m = 1'b0; tick(PH);
  endtask

  task automatic cpu_read(output logic [7:0] d);
    d = bufv;
    cpu_rd = 1'b1; tick(1); cpu_rd = 1'b0; tick(1);
  endtask

  task automatic cpu_wr_addr(input logic [7:0] a);
    cpu_addr = a; cpu_addr_we = 1'b1; tick(1); cpu_addr_we = 1'b0; tick(1);
  endtask

  task automatic clr_irq();
    cpu_irq_clr = 1'b1; tick(1); cpu_irq_clr = 1'b0; tick(1);
  endtask

  task automatic clr_ovf();
    cpu_ovf_clr = 1'b1; tick(1); cpu_ovf_clr = 1'b0; tick(1);
  endtask

  initial begin
    logic       ack;
    logic [7:0] rd;
    tick(3);
    rst_n = 1'b1;
    tick(3);
    // R1 reset state
    chk("R1 scl_pull", scl_pull, 0);
    chk("R1 sda_pull", sda_pull, 0);
    chk("R1 bf", bf, 0);
    chk("R1 ovf", ovf, 0);
    chk("R1 irq", irq, 0);
    chk("R1 upd", upd, 0);

    cpu_wr_addr(8'h84);

    // R2 / R5 / R6: 7-bit address table
    foreach (VEC[k]) begin
      bus_start();
      send_byte(VEC[k][16:9], ack);
      chk("R2 address ack", ack, VEC[k][0]);
      if (VEC[k][0]) begin
        chk("R6 irq after address", irq, 1);
        chk("R5 bf after address", bf, 1);
        cpu_read(rd);
        chk("R5 buffer holds address", rd, VEC[k][16:9]);
        chk("R5 read clears bf", bf, 0);
        clr_irq();
        chk("R6 irq cleared", irq, 0);
        send_byte(VEC[k][8:1], ack);
        chk("R5 data ack", ack, 1);
        cpu_read(rd);
        chk("R5 buffer holds data", rd, VEC[k][8:1]);
        clr_irq();
      end else begin
        chk("R2 no irq on mismatch", irq, 0);
        chk("R2 no bf on mismatch", bf, 0);
        send_byte(8'h3C, ack);
        chk("R2 transfer ignored after mismatch", ack, 0);
      end
      bus_stop();
    end

    // R3 / R4: overflow and status gating
    bus_start();
    send_byte(8'h84, ack);
    chk("R3 address acked", ack, 1);
    clr_irq();
    send_byte(8'h11, ack);
    chk("R3 no ack while full", ack, 0);
    chk("R3 ovf set", ovf, 1);
    chk("R6 irq on refused byte", irq, 1);
    chk("R3 buffer kept", bufv, 8'h84);
    cpu_read(rd);
    clr_irq();
    chk("R4 ovf survives read and irq clear", ovf, 1);
    send_byte(8'h22, ack);
    chk("R4 no ack while ovf set", ack, 0);
    chk("R4 bf stays clear", bf, 0);
    chk("R4 buffer unchanged", bufv, 8'h84);
    clr_ovf();
    chk("R4 ovf cleared by strobe", ovf, 0);
    clr_irq();
    send_byte(8'h33, ack);
    chk("R4 ack after clear", ack, 1);
    chk("R5 buffer after clear", bufv, 8'h33);
    cpu_read(rd);
    clr_irq();
    bus_stop();

    // R7 / R8 / R10: 10-bit two-pass match, address 10'b10_0110_1001
    ten_bit = 1'b1;
    cpu_wr_addr(8'hF4);
    bus_start();
    send_byte(8'hF4, ack);
    chk("R7 header acked", ack, 1);
    chk("R7 update request", upd, 1);
    chk("R7 scl held", scl_pull, 1);
    chk("R7 buffer header", bufv, 8'hF4);
    scl_m = 1'b1; tick(2 * PH);
    chk("R7 scl line stays low", scl_line, 0);
    scl_m = 1'b0; tick(2);
    cpu_read(rd);
    clr_irq();
    chk("R7 still held before write", scl_pull, 1);
    cpu_wr_addr(8'h69);
    chk("R7 write clears update", upd, 0);
    chk("R7 write releases scl", scl_pull, 0);
    send_byte(8'h69, ack);
    chk("R8 low byte acked", ack, 1);
    chk("R8 update request", upd, 1);
    chk("R8 buffer low byte", bufv, 8'h69);
    cpu_read(rd);
    clr_irq();
    cpu_wr_addr(8'hF4);
    send_byte(8'hA5, ack);
    chk("R5 10-bit data acked", ack, 1);
    chk("R11 no hold on data", scl_pull, 0);
    cpu_read(rd);
    chk("R5 10-bit data", rd, 8'hA5);
    clr_irq();
    bus_start();
    send_byte(8'hF5, ack);
    chk("R10 header after restart acked", ack, 1);
    chk("R10 no update request", upd, 0);
    chk("R10 buffer header", bufv, 8'hF5);
    cpu_read(rd);
    clr_irq();
    bus_stop();

    // R9: read header without a completed match
    bus_start();
    send_byte(8'hF5, ack);
    chk("R9 read header refused", ack, 0);
    chk("R9 no irq", irq, 0);
    bus_stop();

    // R10: STOP cancelled the completed match, so a write header stretches again
    bus_start();
    send_byte(8'hF4, ack);
    chk("R10 header after stop acked", ack, 1);
    chk("R10 update requested after stop", upd, 1);
    cpu_read(rd);
    clr_irq();
    cpu_wr_addr(8'h69);
    send_byte(8'h6A, ack);
    chk("R8 low byte mismatch refused", ack, 0);
    chk("R8 no hold on mismatch", scl_pull, 0);
    chk("R8 no irq on mismatch", irq, 0);
    chk("R11 sda released", sda_pull, 0);
    bus_stop();

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule